// File: doc/BRIEF.md
# Scrambled-State Scan Register

This block is a scan register meant to wrap flip-flops that hold secret state. In capture mode every stage loads its functional input through a plain two-way multiplexer, so the functional path carries no added logic. In shift mode the path between stages carries fixed inverters and feed-forward XOR taps from earlier stages. The bits held in the flip-flops are therefore a scrambled image of what an ordinary shift register would hold.

The pattern of inversions and taps is a set of elaboration-time parameters. From that pattern, an elaboration-time function derives an output network: a set of stages XORed together, plus an optional inversion, that drives `scan_out`. This network makes the serial behaviour exactly that of a plain shift register of the same length. A tester that only sees `scan_in` and `scan_out` cannot tell the two apart.

An extra decoy flip-flop sits beside the chain. It follows one stage while shifting. In capture mode it loads either a constant or another stage's functional input, which adds a bit whose origin cannot be inferred from scan traffic.

Top module: `obf_scan_reg`

## Requirements
- R1: While `rst_n` is low, every chain flip-flop (`chain_q`) and the decoy flip-flop (`decoy_q`) read 0.
- R2: On a clock edge with `scan_en` low, `chain_q` takes the value of `func_d`, bit for bit and without modification.
- R3: After any `STAGES` consecutive shift edges (`scan_en` high), `scan_out` equals the `scan_in` bit sampled `STAGES` shift edges earlier, whatever the state was before those shifts.
- R4: With the default pattern, after reset followed by three shifts of 0, `chain_q` is not all zeros; the stored image differs from that of a plain shift register.
- R5: After a capture, the `STAGES` values of `scan_out` read at capture and after each of the next `STAGES-1` shifts form a stream that does not depend on `scan_in` and differs for every captured value. Distinct captured values give distinct streams, so the captured data decodes uniquely. The stream is also affine in the captured value: the stream for `d` equals the stream for 0 XOR the sum of (stream for each single set bit of `d` XOR the stream for 0).
- R6: On a capture edge, `decoy_q` loads its tie source. When `DECOY_TIE` < `STAGES`, the source is `func_d[DECOY_TIE]`; `DECOY_TIE` = `STAGES` selects constant 0, and `DECOY_TIE` = `STAGES`+1 selects constant 1.
- R7: On a shift edge, `decoy_q` loads the value that `chain_q[DECOY_FROM]` held before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| scan_en | input | 1 | 1 = shift, 0 = capture functional data |
| scan_in | input | 1 | Serial scan input |
| func_d | input | STAGES | Functional data from the surrounding logic |
| scan_out | output | 1 | Serial scan output through the derived correction network |
| chain_q | output | STAGES | Raw flip-flop contents toward the functional logic |
| decoy_q | output | 1 | Decoy flip-flop contents |

## Verification
The bench builds two instances. The first is the default three-stage instance: inversions on the first and last stage, one tap from stage 0 into stage 2, and a decoy tied to the stage 0 functional input. Its small width allows all eight captured values to be enumerated, so decode uniqueness and superposition can be checked exhaustively. The second is a six-stage instance with three taps, a different inversion mask and a constant-1 decoy. It drives a deeper correction network, so the delay-equivalence checks cover taps that span several stages.

// File: rtl/obf_scan_pkg.sv
package obf_scan_pkg;

  localparam int MAXS = 32;

  // Symbolic run of the shift path in steady state. Each stage is held as a
  // vector of coefficients over past inputs (bit i -> input i+1 shifts ago)
  // plus a constant. The output set is then chosen greedily so that only the
  // oldest input survives. Result: bit MAXS = output inversion, low bits =
  // stages XORed into the output.
  function automatic logic [MAXS:0] derive_out_net(
      input int                      k,
      input logic [MAXS-1:0]         inv,
      input logic [MAXS*MAXS-1:0]    taps);
    logic [MAXS-1:0] coef [MAXS];
    logic            kc   [MAXS];
    logic [MAXS-1:0] acc;
    logic [MAXS-1:0] sel;
    logic            acc_c;
    for (int j = 0; j < MAXS; j++) begin
      coef[j] = '0;
      kc[j]   = 1'b0;
    end
    coef[0] = MAXS'(1);
    kc[0]   = inv[0];
    for (int j = 1; j < k; j++) begin
      coef[j] = coef[j-1] << 1;
      kc[j]   = kc[j-1] ^ inv[j];
      for (int m = 0; m + 1 < j; m++) begin
        if (taps[j*k+m]) begin
          coef[j] = coef[j] ^ (coef[m] << 1);
          kc[j]   = kc[j] ^ kc[m];
        end
      end
    end
    acc   = coef[k-1];
    acc_c = kc[k-1];
    sel   = '0;
    sel[k-1] = 1'b1;
    for (int i = k - 2; i >= 0; i--) begin
      if (acc[i]) begin
        acc    = acc ^ coef[i];
        acc_c  = acc_c ^ kc[i];
        sel[i] = 1'b1;
      end
    end
    return {acc_c, sel};
  endfunction

endpackage

// File: rtl/obf_scan_cell.sv
module obf_scan_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_en,
  input  logic func_d,
  input  logic shift_d,
  output logic q
);
  logic d_nxt;

  always_comb begin
    d_nxt = scan_en ? shift_d : func_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d_nxt;
  end
endmodule

// File: rtl/obf_scan_decoy.sv
module obf_scan_decoy (
  input  logic clk,
  input  logic rst_n,
  input  logic scan_en,
  input  logic tie_d,
  input  logic follow_d,
  output logic q
);
  logic d_nxt;

  always_comb begin
    d_nxt = scan_en ? follow_d : tie_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d_nxt;
  end

  // R6: capture loads the tie source
  p_decoy_tie_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> q == $past(tie_d));
  // R7: shift follows the chosen stage
  p_decoy_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> q == $past(follow_d));
endmodule

// File: rtl/obf_scan_unscramble.sv
module obf_scan_unscramble #(
  parameter int           STAGES = 3,
  parameter logic [STAGES-1:0] SEL = '1,
  parameter logic         INV    = 1'b0
) (
  input  logic [STAGES-1:0] chain,
  output logic              serial
);
  always_comb begin
    serial = (^(chain & SEL)) ^ INV;
  end
endmodule

// File: rtl/obf_scan_reg.sv
module obf_scan_reg
  import obf_scan_pkg::*;
#(
  parameter int                     STAGES     = 3,
  parameter logic [STAGES-1:0]        INV_MASK   = 3'b101,
  parameter logic [STAGES*STAGES-1:0] TAP_MASK   = 9'b001_000_000,
  parameter int                     DECOY_FROM = 1,
  parameter int                     DECOY_TIE  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              scan_in,
  input  logic [STAGES-1:0] func_d,
  output logic              scan_out,
  output logic [STAGES-1:0] chain_q,
  output logic              decoy_q
);
  localparam logic [MAXS-1:0]      INV_W  = MAXS'(INV_MASK);
  localparam logic [MAXS*MAXS-1:0] TAPS_W = (MAXS*MAXS)'(TAP_MASK);
  localparam logic [MAXS:0]        NET    = derive_out_net(STAGES, INV_W, TAPS_W);
  localparam logic [STAGES-1:0]    OUT_SEL = NET[STAGES-1:0];
  localparam logic                 OUT_INV = NET[MAXS];
  localparam int                   CW      = $clog2(STAGES + 1);

  logic [STAGES-1:0] shift_d;
  logic              decoy_tie;

  // Shift path: previous stage, fixed inversion, feed-forward taps.
  assign shift_d[0] = scan_in ^ INV_MASK[0];

  genvar gj;
  generate
    for (gj = 1; gj < STAGES; gj++) begin : g_path
      localparam logic [STAGES-1:0] TROW =
        TAP_MASK[gj*STAGES +: STAGES] & ((STAGES'(1) << (gj - 1)) - STAGES'(1));
      assign shift_d[gj] = chain_q[gj-1] ^ INV_MASK[gj] ^ (^(chain_q & TROW));
    end

    for (gj = 0; gj < STAGES; gj++) begin : g_cell
      obf_scan_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .scan_en (scan_en),
        .func_d  (func_d[gj]),
        .shift_d (shift_d[gj]),
        .q       (chain_q[gj])
      );
    end

    if (DECOY_TIE < STAGES) begin : g_tie_func
      assign decoy_tie = func_d[DECOY_TIE];
    end else if (DECOY_TIE == STAGES) begin : g_tie_zero
      assign decoy_tie = 1'b0;
    end else begin : g_tie_one
      assign decoy_tie = 1'b1;
    end
  endgenerate

  obf_scan_decoy u_decoy (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_en  (scan_en),
    .tie_d    (decoy_tie),
    .follow_d (chain_q[DECOY_FROM]),
    .q        (decoy_q)
  );

  obf_scan_unscramble #(
    .STAGES (STAGES),
    .SEL    (OUT_SEL),
    .INV    (OUT_INV)
  ) u_unscr (
    .chain  (chain_q),
    .serial (scan_out)
  );

  // Checker state: window of the last STAGES scan_in bits and a saturating
  // count of consecutive shift edges.
  logic [STAGES-1:0] a_hist;
  logic [CW-1:0]     a_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_hist <= '0;
      a_cnt  <= '0;
    end else if (scan_en) begin
      a_hist <= {a_hist[STAGES-2:0], scan_in};
      if (a_cnt != CW'(STAGES)) a_cnt <= a_cnt + CW'(1);
    end else begin
      a_cnt <= '0;
    end
  end

  // R3: serial behaviour equals a plain delay line of STAGES
  p_delay_equiv_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_cnt == CW'(STAGES)) |-> scan_out == a_hist[STAGES-1]);
  // R2: capture stores functional data unchanged
  p_capture_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> chain_q == $past(func_d));
endmodule

// File: tb/obf_scan_reg_test.sv
module obf_scan_reg_test;
  localparam int CLK_P = 10;
  localparam int KA = 3;
  localparam int KB = 6;

  logic clk = 1'b0;
  logic rst_n, scan_en, scan_in;
  logic [KA-1:0] func_a, chain_a;
  logic [KB-1:0] func_b, chain_b;
  logic out_a, out_b, decoy_a, decoy_b;

  int n_chk = 0;
  int n_fail = 0;
  int n_sh = 0;
  logic hist[$];
  logic [KA-1:0] tbl [8];

  always #(CLK_P/2) clk = ~clk;

  obf_scan_reg uut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
    .func_d(func_a), .scan_out(out_a), .chain_q(chain_a), .decoy_q(decoy_a));

  obf_scan_reg #(
    .STAGES(KB), .INV_MASK(6'b010110),
    .TAP_MASK(36'h0_8108_2000), .DECOY_FROM(3), .DECOY_TIE(KB+1)
  ) uut_b (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
    .func_d(func_b), .scan_out(out_b), .chain_q(chain_b), .decoy_q(decoy_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sh(input logic b);
    logic pa, pb;
    @(negedge clk);
    scan_en = 1'b1;
    scan_in = b;
    pa = chain_a[1];
    pb = chain_b[3];
    @(posedge clk);
    #1;
    hist.push_back(b);
    n_sh++;
    if (n_sh >= KA) chk(out_a == hist[n_sh-KA], "R3 k3", out_a, hist[n_sh-KA]);
    if (n_sh >= KB) chk(out_b == hist[n_sh-KB], "R3 k6", out_b, hist[n_sh-KB]);
    chk(decoy_a == pa, "R7 k3", decoy_a, pa);
    chk(decoy_b == pb, "R7 k6", decoy_b, pb);
  endtask

  task automatic cap(input logic [KA-1:0] da, input logic [KB-1:0] db);
    @(negedge clk);
    scan_en = 1'b0;
    func_a = da;
    func_b = db;
    @(posedge clk);
    #1;
    chk(chain_a == da, "R2 k3", chain_a, da);
    chk(chain_b == db, "R2 k6", chain_b, db);
    chk(decoy_a == da[0], "R6 k3", decoy_a, da[0]);
    chk(decoy_b == 1'b1, "R6 k6", decoy_b, 1);
    n_sh = 0;
    hist.delete();
  endtask

  task automatic stream(input logic [KA-1:0] d, input bit rin, output logic [KA-1:0] z);
    cap(d, $urandom);
    z[0] = out_a;
    for (int r = 1; r < KA; r++) begin
      sh(rin ? 1'($urandom) : 1'b0);
      z[r] = out_a;
    end
  endtask

  initial begin
    #(CLK_P*200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [KA-1:0] z, acc;
    rst_n = 1'b0; scan_en = 1'b0; scan_in = 1'b0; func_a = '0; func_b = '0;
    #(CLK_P*3);
    // R1 reset state
    chk(chain_a == '0, "R1 k3 chain", chain_a, 0);
    chk(chain_b == '0, "R1 k6 chain", chain_b, 0);
    chk(decoy_a == 1'b0 && decoy_b == 1'b0, "R1 decoy", {decoy_a, decoy_b}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    scan_en = 1'b1;

    // R4 scrambled image after zero shifts
    for (int i = 0; i < KA; i++) sh(1'b0);
    chk(chain_a != '0, "R4", chain_a, 1);

    // R3 random streams from an arbitrary state
    for (int i = 0; i < 60; i++) sh(1'($urandom));
    for (int i = 0; i < 12; i++) sh(1'b1);
    for (int i = 0; i < 12; i++) sh(1'(i % 2));

    // R5 exhaustive capture streams for the 3-stage instance
    for (int d = 0; d < 8; d++) begin
      stream(3'(d), 1'b0, z);
      tbl[d] = z;
    end
    for (int d = 0; d < 8; d++) begin
      stream(3'(d), 1'b1, z);
      chk(z == tbl[d], "R5 scan_in independence", z, tbl[d]);
    end
    for (int a = 0; a < 8; a++)
      for (int b = a + 1; b < 8; b++)
        chk(tbl[a] != tbl[b], "R5 unique decode", tbl[a], tbl[b]);
    for (int d = 0; d < 8; d++) begin
      acc = tbl[0];
      for (int m = 0; m < KA; m++)
        if (d[m]) acc = acc ^ tbl[1 << m] ^ tbl[0];
      chk(tbl[d] == acc, "R5 superposition", tbl[d], acc);
    end
    for (int i = 0; i < 10; i++) begin
      logic [KA-1:0] d;
      int found;
      d = 3'($urandom);
      stream(d, 1'b1, z);
      found = -1;
      for (int c = 0; c < 8; c++) if (tbl[c] == z) found = c;
      chk(found == int'(d), "R5 decode", found, d);
    end

    // R3 resumes after a capture, R2/R6 on captures of the longer chain
    cap(3'b110, 6'b101101);
    for (int i = 0; i < 40; i++) sh(1'($urandom));
    cap(3'b001, 6'b010010);
    for (int i = 0; i < 20; i++) sh(1'($urandom));

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule